// File: doc/BRIEF.md
# DMA Channel Source-Address and Request-Source Control

This block is the control slice of one DMA channel. It holds a small channel control word made of an enable bit, a transfer-size field, a source-address mode field and a request-source selector. It also holds the 32-bit source address. On each completed transfer beat reported by the bus side, the address is held, stepped up or stepped down. The step size follows the transfer size: 1, 2 or 4 bytes, or 16 bytes for a burst.

The selector decides what makes the channel request a transfer. The choices are an external request line (dual-address, or single-address in either direction), a free-running auto request, an expansion-module request, an ADC request or a timer request. Combinations that are prohibited set a sticky configuration-error flag. The flag stops both requests and address updates until a later control write produces a legal word.

External request sources are legal only on the two lowest-numbered channels, which a channel-number parameter selects. The selector can only be changed while the channel is disabled. The destination address, the transfer count, bus mastering and arbitration between channels live elsewhere and reach this block only as the beat strobe.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, the control word reads 0, the source address is 0, and `cfg_err` and `dma_req` are 0.
- R2: The control word layout is: bit 0 enable, bits 2:1 size (00 byte, 01 halfword, 10 word, 11 16-byte burst), bits 4:3 address mode (00 fixed, 01 increment, 10 decrement, 11 reserved), bits 8:5 request source. When the mode is increment and an accepted beat occurs, the address grows by 1, 2, 4 or 16 according to the size, one cycle after the beat.
- R3: When the mode is decrement and an accepted beat occurs, the address shrinks by 1, 2 or 4 for the byte, halfword and word sizes.
- R4: When the mode is fixed, an accepted beat leaves the address unchanged.
- R5: When the request source is 0011 (single-address, device to memory), beats never change the address, and the mode field is not checked for legality.
- R6: A control write made while the enable bit currently reads 1 updates the enable, size and mode fields but keeps the old request source. When the channel is disabled, the whole word is taken.
- R7: A write that leaves any of the following in the control word sets `cfg_err` on the next cycle: mode 11; a 16-byte size with the fixed or decrement mode; a request source other than 0000, 0010, 0011, 0100, 1000, 1110 or 1111. The flag stays set until a control write leaves a legal word.
- R8: On a channel whose number is 2 or higher, the external sources 0000, 0010 and 0011 are illegal and set `cfg_err`. On channels 0 and 1 they are legal.
- R9: While `cfg_err` is 1, `dma_req` is 0 and beats do not change the address.
- R10: With source 0100 (auto), `dma_req` is 1 in every cycle in which the channel is enabled and error-free.
- R11: `dma_req` follows the selected input: `req_ext` for 0000, 0010 and 0011; `req_exp` for 1000; `req_adc` for 1110; `req_tmr` for 1111. It is 0 whenever the enable bit is 0.
- R12: The address wraps modulo 2^32 in both directions. A load through `addr_we` takes priority over a beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word write data |
| addr_we | input | 1 | Source address load strobe |
| addr_wdata | input | 32 | Source address load value |
| beat_done | input | 1 | One transfer beat completed |
| req_ext | input | 1 | External device request line |
| req_exp | input | 1 | Expansion-module request |
| req_adc | input | 1 | ADC request |
| req_tmr | input | 1 | Timer request |
| ctrl_q | output | 9 | Current control word |
| src_addr | output | 32 | Current source address |
| dma_req | output | 1 | Transfer request to the arbiter |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The hardest case to reach is a control write that lands while the channel is enabled and tries to move the selector. The write must be partly accepted: the enable, size and mode fields change and the selector does not. A following write that only clears enable must also leave the selector alone, because the enable bit still reads 1 at that moment. The stimulus reaches this by enabling an auto-request channel, writing a new source, then disabling and re-enabling with the new source, while comparing the control word each cycle. A second instance built as channel 2 receives the same stimulus, so the same external-source writes must be legal on one channel and flagged on the other.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;

   localparam logic [1:0] SZ_BYTE  = 2'b00;
   localparam logic [1:0] SZ_HALF  = 2'b01;
   localparam logic [1:0] SZ_WORD  = 2'b10;
   localparam logic [1:0] SZ_BURST = 2'b11;

   localparam logic [1:0] AM_FIXED = 2'b00;
   localparam logic [1:0] AM_INC   = 2'b01;
   localparam logic [1:0] AM_DEC   = 2'b10;
   localparam logic [1:0] AM_RSVD  = 2'b11;

   localparam logic [3:0] RQ_EXT_DUAL = 4'h0;
   localparam logic [3:0] RQ_EXT_M2D  = 4'h2;
   localparam logic [3:0] RQ_EXT_D2M  = 4'h3;
   localparam logic [3:0] RQ_AUTO     = 4'h4;
   localparam logic [3:0] RQ_EXPAN    = 4'h8;
   localparam logic [3:0] RQ_ADC      = 4'hE;
   localparam logic [3:0] RQ_TIMER    = 4'hF;

   typedef struct packed {
      logic [3:0] rsel;
      logic [1:0] amode;
      logic [1:0] xsize;
      logic       en;
   } chan_cfg_t;

   localparam int CFG_W  = $bits(chan_cfg_t);
   localparam int STEP_W = 5;

   function automatic logic [STEP_W-1:0] step_of(input logic [1:0] sz);
      logic [STEP_W-1:0] s;
      case (sz)
         SZ_BYTE: s = 5'd1;
         SZ_HALF: s = 5'd2;
         SZ_WORD: s = 5'd4;
         default: s = 5'd16;
      endcase
      return s;
   endfunction

   function automatic logic is_ext_src(input logic [3:0] rs);
      return (rs == RQ_EXT_DUAL) || (rs == RQ_EXT_M2D) || (rs == RQ_EXT_D2M);
   endfunction

endpackage

// File: rtl/dma_cc_reg.sv
module dma_cc_reg
   import dma_cc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic             cand_legal,
   output chan_cfg_t        cand,
   output chan_cfg_t        cfg,
   output logic             err
);

   chan_cfg_t wr;

   always_comb begin
      wr   = chan_cfg_t'(wdata);
      cand = wr;
      if (cfg.en) begin
         cand.rsel = cfg.rsel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
         err <= 1'b0;
      end else if (we) begin
         cfg <= cand;
         err <= !cand_legal;
      end
   end

endmodule

// File: rtl/dma_cc_legal.sv
module dma_cc_legal
   import dma_cc_pkg::*;
#(
   parameter bit EXT_OK = 1'b1
) (
   input  chan_cfg_t c,
   output logic      legal
);

   logic src_known;
   logic src_allowed;
   logic mode_ok;

   always_comb begin
      case (c.rsel)
         RQ_EXT_DUAL, RQ_EXT_M2D, RQ_EXT_D2M,
         RQ_AUTO, RQ_EXPAN, RQ_ADC, RQ_TIMER: src_known = 1'b1;
         default:                              src_known = 1'b0;
      endcase
   end

   generate
      if (EXT_OK) begin : g_ext_allowed
         assign src_allowed = src_known;
      end else begin : g_ext_blocked
         assign src_allowed = src_known && !is_ext_src(c.rsel);
      end
   endgenerate

   always_comb begin
      if (c.rsel == RQ_EXT_D2M) begin
         mode_ok = 1'b1;
      end else if (c.amode == AM_RSVD) begin
         mode_ok = 1'b0;
      end else if (c.xsize == SZ_BURST) begin
         mode_ok = (c.amode == AM_INC);
      end else begin
         mode_ok = 1'b1;
      end
   end

   assign legal = src_allowed && mode_ok;

endmodule

// File: rtl/dma_cc_reqmux.sv
module dma_cc_reqmux
   import dma_cc_pkg::*;
(
   input  chan_cfg_t cfg,
   input  logic      err,
   input  logic      req_ext,
   input  logic      req_exp,
   input  logic      req_adc,
   input  logic      req_tmr,
   output logic      req
);

   logic sel_req;

   always_comb begin
      case (cfg.rsel)
         RQ_EXT_DUAL, RQ_EXT_M2D, RQ_EXT_D2M: sel_req = req_ext;
         RQ_AUTO:                             sel_req = 1'b1;
         RQ_EXPAN:                            sel_req = req_exp;
         RQ_ADC:                              sel_req = req_adc;
         RQ_TIMER:                            sel_req = req_tmr;
         default:                             sel_req = 1'b0;
      endcase
   end

   assign req = cfg.en && !err && sel_req;

endmodule

// File: rtl/dma_cc_addr.sv
module dma_cc_addr
   import dma_cc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_en,
   input  logic [1:0]        amode,
   input  logic [1:0]        xsize,
   output logic [ADDR_W-1:0] addr
);

   localparam int PAD_W = ADDR_W - STEP_W;

   logic [ADDR_W-1:0] step_w;
   logic [ADDR_W-1:0] nxt;

   generate
      if (PAD_W > 0) begin : g_pad
         assign step_w = {{PAD_W{1'b0}}, step_of(xsize)};
      end else begin : g_nopad
         assign step_w = step_of(xsize);
      end
   endgenerate

   always_comb begin
      case (amode)
         AM_INC:  nxt = addr + step_w;
         AM_DEC:  nxt = addr - step_w;
         default: nxt = addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (step_en) begin
         addr <= nxt;
      end
   end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_cc_pkg::*;
#(
   parameter int CHAN_ID   = 0,
   parameter int NUM_CHAN  = 4,
   parameter int EXT_CHANS = 2,
   parameter int ADDR_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              addr_we,
   input  logic [ADDR_W-1:0] addr_wdata,
   input  logic              beat_done,
   input  logic              req_ext,
   input  logic              req_exp,
   input  logic              req_adc,
   input  logic              req_tmr,
   output logic [CFG_W-1:0]  ctrl_q,
   output logic [ADDR_W-1:0] src_addr,
   output logic              dma_req,
   output logic              cfg_err
);

   localparam bit EXT_OK = (CHAN_ID < EXT_CHANS);

   generate
      if (CHAN_ID < 0 || CHAN_ID >= NUM_CHAN) begin : g_bad_chan
         $error("dma_chan_ctrl: CHAN_ID out of range");
      end
      if (EXT_CHANS > NUM_CHAN) begin : g_bad_ext
         $error("dma_chan_ctrl: EXT_CHANS exceeds NUM_CHAN");
      end
      if (ADDR_W < STEP_W) begin : g_bad_aw
         $error("dma_chan_ctrl: ADDR_W too small for burst step");
      end
   endgenerate

   chan_cfg_t cand;
   chan_cfg_t cfg;
   logic      cand_legal;
   logic      err;
   logic      step_en;

   dma_cc_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .wdata      (cfg_wdata),
      .cand_legal (cand_legal),
      .cand       (cand),
      .cfg        (cfg),
      .err        (err)
   );

   dma_cc_legal #(.EXT_OK(EXT_OK)) u_legal (
      .c     (cand),
      .legal (cand_legal)
   );

   dma_cc_reqmux u_mux (
      .cfg     (cfg),
      .err     (err),
      .req_ext (req_ext),
      .req_exp (req_exp),
      .req_adc (req_adc),
      .req_tmr (req_tmr),
      .req     (dma_req)
   );

   assign step_en = beat_done && cfg.en && !err && (cfg.rsel != RQ_EXT_D2M);

   dma_cc_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_we),
      .load_val (addr_wdata),
      .step_en  (step_en),
      .amode    (cfg.amode),
      .xsize    (cfg.xsize),
      .addr     (src_addr)
   );

   assign ctrl_q  = cfg;
   assign cfg_err = err;

endmodule

// File: rtl/dma_cc_chk.sv
module dma_cc_chk
   import dma_cc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              addr_we,
   input logic              beat_done,
   input logic [CFG_W-1:0]  ctrl_q,
   input logic [ADDR_W-1:0] src_addr,
   input logic              dma_req,
   input logic              cfg_err
);

   chan_cfg_t c;
   assign c = chan_cfg_t'(ctrl_q);

   // R9
   err_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !dma_req);

   // R11
   off_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c.en |-> !dma_req);

   // R10
   auto_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c.en && !cfg_err && c.rsel == RQ_AUTO) |-> dma_req);

   // R6
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && c.en) |=> (ctrl_q[8:5] == $past(ctrl_q[8:5])));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && cfg_err) |=> cfg_err);

   // R4
   fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_we && c.amode == AM_FIXED) |=> $stable(src_addr));

   // R5
   d2m_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_we && c.rsel == RQ_EXT_D2M) |=> $stable(src_addr));

   // R2
   inc_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_done && !addr_we && c.en && !cfg_err && c.amode == AM_INC &&
       c.xsize == SZ_BYTE && c.rsel != RQ_EXT_D2M)
      |=> (src_addr == $past(src_addr) + ADDR_W'(1)));

endmodule

bind dma_chan_ctrl dma_cc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .addr_we   (addr_we),
   .beat_done (beat_done),
   .ctrl_q    (ctrl_q),
   .src_addr  (src_addr),
   .dma_req   (dma_req),
   .cfg_err   (cfg_err)
);

// File: tb/sim_dma_chan_ctrl.sv
`timescale 1ns/100ps
module sim_dma_chan_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_wdata = '0;
   logic        addr_we = 1'b0;
   logic [31:0] addr_wdata = '0;
   logic        beat_done = 1'b0;
   logic        req_ext = 1'b0, req_exp = 1'b0, req_adc = 1'b0, req_tmr = 1'b0;

   logic [8:0]  ctrl_q0, ctrl_q1;
   logic [31:0] addr0, addr1;
   logic        req0, req1, err0, err1;

   always #2.5 clk = ~clk;

   dma_chan_ctrl #(.CHAN_ID(0)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .addr_we(addr_we), .addr_wdata(addr_wdata), .beat_done(beat_done),
      .req_ext(req_ext), .req_exp(req_exp), .req_adc(req_adc), .req_tmr(req_tmr),
      .ctrl_q(ctrl_q0), .src_addr(addr0), .dma_req(req0), .cfg_err(err0));

   dma_chan_ctrl #(.CHAN_ID(2)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .addr_we(addr_we), .addr_wdata(addr_wdata), .beat_done(beat_done),
      .req_ext(req_ext), .req_exp(req_exp), .req_adc(req_adc), .req_tmr(req_tmr),
      .ctrl_q(ctrl_q1), .src_addr(addr1), .dma_req(req1), .cfg_err(err1));

   int checks = 0, fails = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int          m_en, m_sz, m_md, m_sel;
   bit          m_err [2];
   logic [31:0] m_addr [2];
   int          chan_of [2] = '{0, 2};

   function automatic bit legal(int ch, int sel, int md, int sz);
      bit known = (sel == 0 || sel == 2 || sel == 3 || sel == 4 ||
                   sel == 8 || sel == 14 || sel == 15);
      bit ext = (sel == 0 || sel == 2 || sel == 3);
      if (!known) return 0;
      if (ext && ch >= 2) return 0;
      if (sel == 3) return 1;
      if (md == 3) return 0;
      if (sz == 3 && md != 1) return 0;
      return 1;
   endfunction

   function automatic bit exp_req(int k);
      bit s;
      if (!m_en || m_err[k]) return 0;
      case (m_sel)
         0, 2, 3: s = req_ext;
         4:       s = 1;
         8:       s = req_exp;
         14:      s = req_adc;
         15:      s = req_tmr;
         default: s = 0;
      endcase
      return s;
   endfunction

   task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic compare_all();
      logic [8:0] ec;
      ec = {m_sel[3:0], m_md[1:0], m_sz[1:0], m_en[0]};
      chk("ctrl0", 32'(ctrl_q0), 32'(ec));
      chk("ctrl2", 32'(ctrl_q1), 32'(ec));
      chk("addr0", addr0, m_addr[0]);
      chk("addr2", addr1, m_addr[1]);
      chk("err0", 32'(err0), 32'(m_err[0]));
      chk("err2", 32'(err1), 32'(m_err[1]));
      chk("req0", 32'(req0), 32'(exp_req(0)));
      chk("req2", 32'(req1), 32'(exp_req(1)));
   endtask

   task automatic model_edge();
      int step;
      if (!rst_n) begin
         m_en = 0; m_sz = 0; m_md = 0; m_sel = 0;
         for (int k = 0; k < 2; k++) begin m_err[k] = 0; m_addr[k] = 0; end
         return;
      end
      step = (m_sz == 0) ? 1 : (m_sz == 1) ? 2 : (m_sz == 2) ? 4 : 16;
      for (int k = 0; k < 2; k++) begin
         if (addr_we) m_addr[k] = addr_wdata;
         else if (beat_done && m_en && !m_err[k] && m_sel != 3) begin
            if (m_md == 1) m_addr[k] = m_addr[k] + 32'(step);
            else if (m_md == 2) m_addr[k] = m_addr[k] - 32'(step);
         end
      end
      if (cfg_we) begin
         if (!m_en) m_sel = int'(cfg_wdata[8:5]);
         m_en = int'(cfg_wdata[0]);
         m_sz = int'(cfg_wdata[2:1]);
         m_md = int'(cfg_wdata[4:3]);
         for (int k = 0; k < 2; k++) m_err[k] = !legal(chan_of[k], m_sel, m_md, m_sz);
      end
   endtask

   // one cycle: drive at negedge, compare, update model at posedge
   task automatic cyc(bit we, logic [8:0] wd, bit awe, logic [31:0] av, bit beat,
                      logic [3:0] rq);
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; addr_we = awe; addr_wdata = av; beat_done = beat;
      {req_tmr, req_adc, req_exp, req_ext} = rq;
      #1 compare_all();
      @(posedge clk);
      model_edge();
   endtask

   function automatic logic [8:0] cw(int sel, int md, int sz, int en);
      return {sel[3:0], md[1:0], sz[1:0], en[0]};
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 0, 4'h0);
   endtask

   task automatic beats(int n);
      for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, 1, 4'h0);
   endtask

   task automatic wr(logic [8:0] w);
      cyc(1, w, 0, '0, 0, 4'h0);
   endtask

   task automatic ld(logic [31:0] a);
      cyc(0, '0, 1, a, 0, 4'h0);
   endtask

   initial begin
      model_edge();
      // R1 reset state
      tag = "R1";
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 increment, all sizes
      tag = "R2";
      ld(32'h100);
      for (int sz = 0; sz < 4; sz++) begin
         wr(cw(4, 1, sz, 0));
         wr(cw(4, 1, sz, 1));
         beats(3);
      end

      // R3 decrement
      tag = "R3";
      wr(cw(4, 2, 0, 0));
      for (int sz = 0; sz < 3; sz++) begin
         wr(cw(4, 2, sz, 1));
         beats(3);
      end

      // R4 fixed
      tag = "R4";
      wr(cw(4, 0, 2, 1));
      beats(4);

      // R12 wrap and load priority
      tag = "R12";
      ld(32'hFFFF_FFFE);
      wr(cw(4, 1, 2, 1));
      beats(1);
      ld(32'h0000_0001);
      wr(cw(4, 2, 2, 1));
      beats(1);
      cyc(0, '0, 1, 32'h1234_5678, 1, 4'h0);
      idle(1);

      // R6 selector frozen while enabled
      tag = "R6";
      wr(cw(8, 1, 0, 1));
      idle(1);
      wr(cw(8, 1, 0, 0));
      idle(1);
      wr(cw(8, 1, 0, 1));
      cyc(0, '0, 0, '0, 0, 4'b0010);
      cyc(0, '0, 0, '0, 0, 4'b0000);
      wr(cw(4, 1, 0, 0));

      // R5 device-to-memory: no update, mode unchecked
      tag = "R5";
      wr(cw(3, 3, 3, 1));
      beats(3);
      cyc(0, '0, 0, '0, 1, 4'b0001);
      wr(cw(3, 1, 0, 0));

      // R7 prohibited settings, sticky
      tag = "R7";
      wr(cw(4, 3, 0, 1));
      beats(2);
      wr(cw(4, 0, 3, 1));
      beats(2);
      wr(cw(4, 2, 3, 1));
      beats(2);
      wr(cw(4, 1, 3, 0));
      wr(cw(5, 1, 0, 1));
      beats(2);
      wr(cw(4, 1, 3, 0));
      wr(cw(4, 1, 3, 1));
      beats(2);
      wr(cw(4, 1, 0, 0));

      // R8 external sources per channel
      tag = "R8";
      for (int s = 0; s < 4; s++) begin
         if (s == 1) continue;
         wr(cw(s, 1, 0, 0));
         wr(cw(s, 1, 0, 1));
         cyc(0, '0, 0, '0, 1, 4'b0001);
         cyc(0, '0, 0, '0, 1, 4'b0000);
         wr(cw(s, 1, 0, 0));
      end

      // R9 error blocks requests and updates
      tag = "R9";
      wr(cw(7, 1, 0, 0));
      wr(cw(7, 1, 0, 1));
      for (int i = 0; i < 4; i++) cyc(0, '0, 0, '0, 1, 4'hF);
      wr(cw(4, 1, 0, 0));

      // R10 auto request every cycle
      tag = "R10";
      wr(cw(4, 0, 0, 1));
      idle(5);
      wr(cw(4, 0, 0, 0));
      idle(2);

      // R11 per-source pass-through and enable gating
      tag = "R11";
      foreach (chan_of[j]) begin end
      for (int s = 0; s < 16; s++) begin
         if (!(s == 8 || s == 14 || s == 15 || s == 2)) continue;
         wr(cw(s, 0, 0, 0));
         for (int p = 0; p < 16; p++) cyc(0, '0, 0, '0, 0, 4'(p));
         wr(cw(s, 0, 0, 1));
         for (int p = 0; p < 16; p++) cyc(0, '0, 0, '0, 0, 4'(p));
         wr(cw(s, 0, 0, 0));
      end

      // mixed stimulus against the model
      tag = "R9";
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 5) == 0, 9'($urandom), ($urandom % 23) == 0, $urandom,
             ($urandom % 2) == 0, 4'($urandom));
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule